// File: doc/BRIEF.md
# Three-Level PWM Command Qualifier

This block sits between the two threshold comparators of a three-level PWM input and the gate sequencer of a synchronous buck power stage. One comparator flag reports that the pin is above the upper threshold and the other that it is below the lower threshold. When neither flag is set, the pin is inside the mid-level shutdown window, which is where a floating pin settles. The block samples both flags through a synchronizer chain. From them it produces a command that is low, high or tri-state, plus one tri-state flag for the low-side gate path and one for the high-side gate path.

Narrow glitches must not produce switching pulses shorter than the power stage tolerates. A captured high level is therefore stretched to a minimum high time, and a captured low level to a minimum low time. The mid window is qualified by one run-length counter compared against two hold-off limits. The high-side path is released first, on the shorter limit, and the low-side path later, on the longer limit. Leaving tri-state needs a short run of valid levels before either gate is driven again. A sample with both comparator flags set is physically impossible. It is treated as invalid and freezes the qualifier.

All times are clock-cycle parameters. The defaults are set for a 200 MHz clock: 30 cycles low-side hold-off, 17 cycles high-side hold-off, 3 cycles exit delay, 5 cycles minimum high and 13 cycles minimum low.

Top module: `pwm_tri_qualifier`

## Requirements
- R1: A change between valid levels on the comparator inputs appears on `cmd_o` on the third rising clock edge after the inputs change: SYNC_STAGES synchronizer flops plus one state register.
- R2: `cmd_o` is encoded 2'b00 for low, 2'b01 for high and 2'b10 for tri-state, and is never 2'b11. A sample with `above_hi_i`=1 and `below_lo_i`=0 is the high level. A sample with 0/1 is the low level. A sample with 0/0 is the mid window. A sample with 1/1 is invalid.
- R3: While `rst` is high, and in the cycle after it falls, both tri-state flags are 1 and `cmd_o` is 2'b10.
- R4: Once the command goes high it stays high for at least MIN_HIGH_CYC cycles. A high input pulse of P cycles preceded and followed by long low levels gives max(P, MIN_HIGH_CYC) cycles of high command.
- R5: Once the command goes low it stays low for at least MIN_LOW_CYC cycles. A low pulse of P cycles between long high levels gives max(P, MIN_LOW_CYC) cycles of low command.
- R6: `gh_tri_o` sets on the HOLD_GH_CYC-th consecutive mid-window sample. A mid burst of P cycles from a steady low level keeps it set for P+EXIT_CYC-HOLD_GH_CYC cycles when P >= HOLD_GH_CYC, and never sets it otherwise.
- R7: `gl_tri_o` behaves the same way with HOLD_GL_CYC in place of HOLD_GH_CYC.
- R8: The mid-window run counter restarts whenever a valid level is sampled. Two mid bursts of HOLD_GH_CYC-1 cycles separated by two low cycles set no tri-state flag.
- R9: While in tri-state, EXIT_CYC consecutive valid-level samples clear both flags in the same cycle and load the last sampled level. A mid sample restarts that count.
- R10: An invalid sample changes neither the command, the tri-state flags, the mid-window count nor the exit count.
- R11: While either flag is set, `cmd_o` is 2'b10 and the level state is frozen. Before the hold-off expires, a mid-window input leaves the previous level on `cmd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| above_hi_i | input | 1 | Comparator flag: pin above the upper threshold (asynchronous) |
| below_lo_i | input | 1 | Comparator flag: pin below the lower threshold (asynchronous) |
| cmd_o | output | 2 | Qualified command: 00 low, 01 high, 10 tri-state |
| gl_tri_o | output | 1 | Tri-state request for the low-side gate path |
| gh_tri_o | output | 1 | Tri-state request for the high-side gate path |

## Verification
Isolated high pulses and isolated low pulses are swept in width across the minimum-width limits. This separates correct stretching from pass-through and from stretching by the wrong amount. Mid-window bursts are swept from one cycle to past the longer hold-off, so the duration of each flag shows both hold-off limits and the exit delay to the exact cycle. Split mid bursts, mid samples inserted during an exit, and runs of invalid samples taken from high, tri-state and mid-exit conditions show the difference between restarting a count and holding it.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_TRI  = 2'b10
  } cmd_e;

  typedef enum logic [1:0] {
    SMP_MID  = 2'b00,
    SMP_LOW  = 2'b01,
    SMP_HIGH = 2'b10,
    SMP_BAD  = 2'b11
  } smp_e;

  function automatic smp_e classify(input logic above, input logic below);
    case ({above, below})
      2'b10:   return SMP_HIGH;
      2'b01:   return SMP_LOW;
      2'b11:   return SMP_BAD;
      default: return SMP_MID;
    endcase
  endfunction

endpackage

// File: rtl/pwmq_sync.sv
module pwmq_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 1); // R1
  end

endmodule

// File: rtl/pwmq_level.sv
module pwmq_level
  import pwmq_pkg::*;
#(
  parameter int MIN_HI = 5,
  parameter int MIN_LO = 13
) (
  input  logic clk,
  input  logic rst,
  input  smp_e smp_i,
  input  logic freeze_i,
  input  logic load_i,
  output logic lvl_o
);

  localparam int MAXW = (MIN_HI > MIN_LO) ? MIN_HI : MIN_LO;
  localparam int RW   = $clog2(MAXW + 1);
  localparam logic [RW-1:0] HI_RELOAD = RW'(MIN_HI - 1);
  localparam logic [RW-1:0] LO_RELOAD = RW'(MIN_LO - 1);

  logic          lvl_q;
  logic [RW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      rem_q <= '0;
    end else if (load_i) begin
      if (smp_i == SMP_HIGH) begin
        lvl_q <= 1'b1;
        rem_q <= HI_RELOAD;
      end else begin
        lvl_q <= 1'b0;
        rem_q <= LO_RELOAD;
      end
    end else if (!freeze_i) begin
      if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end else if (smp_i == SMP_HIGH && !lvl_q) begin
        lvl_q <= 1'b1;
        rem_q <= HI_RELOAD;
      end else if (smp_i == SMP_LOW && lvl_q) begin
        lvl_q <= 1'b0;
        rem_q <= LO_RELOAD;
      end
    end
  end

  assign lvl_o = lvl_q;

  AST_RISE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($rose(lvl_q) && !$past(load_i)) |-> ($past(rem_q) == '0)); // R4
  AST_HIGH_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_q) |-> (rem_q == HI_RELOAD)); // R4
  AST_LOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(lvl_q) |-> (rem_q == LO_RELOAD)); // R5
  AST_FROZEN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ($past(freeze_i) && !$past(load_i) && !$past(rst)) |-> $stable(lvl_q)); // R11

endmodule

// File: rtl/pwmq_tri.sv
module pwmq_tri
  import pwmq_pkg::*;
#(
  parameter int HOLD_GL = 30,
  parameter int HOLD_GH = 17,
  parameter int EXIT    = 3
) (
  input  logic clk,
  input  logic rst,
  input  smp_e smp_i,
  output logic tri_gl_o,
  output logic tri_gh_o,
  output logic load_o
);

  localparam int HMAX = (HOLD_GL > HOLD_GH) ? HOLD_GL : HOLD_GH;
  localparam int MW   = $clog2(HMAX + 1);
  localparam int EW   = $clog2(EXIT + 1);
  localparam logic [MW-1:0] GL_LIM   = MW'(HOLD_GL);
  localparam logic [MW-1:0] GH_LIM   = MW'(HOLD_GH);
  localparam logic [MW-1:0] MID_SAT  = MW'(HMAX);
  localparam logic [EW-1:0] EXIT_LIM = EW'(EXIT - 1);

  logic [MW-1:0] mid_q;
  logic [MW-1:0] mid_nxt;
  logic [EW-1:0] exit_q;
  logic          gl_q, gh_q;
  logic          in_tri;
  logic          valid;

  assign in_tri  = gl_q | gh_q;
  assign valid   = (smp_i == SMP_LOW) || (smp_i == SMP_HIGH);
  assign mid_nxt = (mid_q == MID_SAT) ? MID_SAT : mid_q + 1'b1;
  assign load_o  = in_tri && valid && (exit_q >= EXIT_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q  <= '0;
      exit_q <= '0;
      gl_q   <= 1'b1;
      gh_q   <= 1'b1;
    end else begin
      case (smp_i)
        SMP_MID: begin
          mid_q  <= mid_nxt;
          exit_q <= '0;
          if (mid_nxt >= GH_LIM) gh_q <= 1'b1;
          if (mid_nxt >= GL_LIM) gl_q <= 1'b1;
        end
        SMP_LOW, SMP_HIGH: begin
          mid_q <= '0;
          if (load_o) begin
            gl_q   <= 1'b0;
            gh_q   <= 1'b0;
            exit_q <= '0;
          end else if (in_tri) begin
            exit_q <= exit_q + 1'b1;
          end else begin
            exit_q <= '0;
          end
        end
        default: begin
          mid_q  <= mid_q;
          exit_q <= exit_q;
        end
      endcase
    end
  end

  assign tri_gl_o = gl_q;
  assign tri_gh_o = gh_q;

  AST_GH_NEEDS_MID: assert property (@(posedge clk) disable iff (rst)
    $rose(gh_q) |-> ($past(smp_i) == SMP_MID)); // R6
  AST_GL_NEEDS_MID: assert property (@(posedge clk) disable iff (rst)
    $rose(gl_q) |-> ($past(smp_i) == SMP_MID)); // R7
  AST_EXIT_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    ($fell(gl_q) || $fell(gh_q)) |-> (!gl_q && !gh_q)); // R9
  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(smp_i) == SMP_BAD) |->
      ($stable(gl_q) && $stable(gh_q) && $stable(mid_q) && $stable(exit_q))); // R10

endmodule

// File: rtl/pwm_tri_qualifier.sv
module pwm_tri_qualifier
  import pwmq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_GL_CYC  = 30,
  parameter int HOLD_GH_CYC  = 17,
  parameter int EXIT_CYC     = 3,
  parameter int MIN_HIGH_CYC = 5,
  parameter int MIN_LOW_CYC  = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       above_hi_i,
  input  logic       below_lo_i,
  output logic [1:0] cmd_o,
  output logic       gl_tri_o,
  output logic       gh_tri_o
);

  localparam int FLAG_W = 2;

  logic [FLAG_W-1:0] flags_s;
  smp_e              smp;
  logic              tri_gl, tri_gh, load, lvl;

  pwmq_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (FLAG_W)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i({above_hi_i, below_lo_i}),
    .q_o(flags_s)
  );

  assign smp = classify(flags_s[1], flags_s[0]);

  pwmq_tri #(
    .HOLD_GL(HOLD_GL_CYC),
    .HOLD_GH(HOLD_GH_CYC),
    .EXIT   (EXIT_CYC)
  ) u_tri (
    .clk     (clk),
    .rst     (rst),
    .smp_i   (smp),
    .tri_gl_o(tri_gl),
    .tri_gh_o(tri_gh),
    .load_o  (load)
  );

  pwmq_level #(
    .MIN_HI(MIN_HIGH_CYC),
    .MIN_LO(MIN_LOW_CYC)
  ) u_level (
    .clk     (clk),
    .rst     (rst),
    .smp_i   (smp),
    .freeze_i(tri_gl | tri_gh),
    .load_i  (load),
    .lvl_o   (lvl)
  );

  always_comb begin
    if (tri_gl || tri_gh) cmd_o = CMD_TRI;
    else if (lvl)         cmd_o = CMD_HIGH;
    else                  cmd_o = CMD_LOW;
  end

  assign gl_tri_o = tri_gl;
  assign gh_tri_o = tri_gh;

  initial begin
    AST_PARAMS_SANE: assert (HOLD_GL_CYC >= 1 && HOLD_GH_CYC >= 1 && EXIT_CYC >= 1
                             && MIN_HIGH_CYC >= 1 && MIN_LOW_CYC >= 1); // R6
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cmd_o != 2'b11); // R2
  AST_INVALID_KEEPS_CMD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(smp) == SMP_BAD) |-> $stable(cmd_o)); // R10
  AST_LOAD_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    load |-> (smp == SMP_LOW || smp == SMP_HIGH)); // R9

endmodule

// File: tb/test_pwm_tri_qualifier.sv
module test_pwm_tri_qualifier;

  localparam int HGL = 30;
  localparam int HGH = 17;
  localparam int EXT = 3;
  localparam int MHI = 5;
  localparam int MLO = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       above = 1'b0;
  logic       below = 1'b0;
  logic [1:0] cmd;
  logic       gl, gh;

  int nchk = 0;
  int nerr = 0;
  int n_hi, n_lo, n_tri, n_gl, n_gh, n_all;

  always #2 clk = ~clk;

  pwm_tri_qualifier #(
    .SYNC_STAGES (2),
    .HOLD_GL_CYC (HGL),
    .HOLD_GH_CYC (HGH),
    .EXIT_CYC    (EXT),
    .MIN_HIGH_CYC(MHI),
    .MIN_LOW_CYC (MLO)
  ) i_pwm_tri_qualifier (
    .clk       (clk),
    .rst       (rst),
    .above_hi_i(above),
    .below_lo_i(below),
    .cmd_o     (cmd),
    .gl_tri_o  (gl),
    .gh_tri_o  (gh)
  );

  typedef enum int {LV_LOW, LV_HIGH, LV_MID, LV_BAD} lv_e;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear();
    n_hi = 0; n_lo = 0; n_tri = 0; n_gl = 0; n_gh = 0; n_all = 0;
  endtask

  task automatic run(input lv_e lv, input int n);
    case (lv)
      LV_HIGH: begin above = 1'b1; below = 1'b0; end
      LV_LOW:  begin above = 1'b0; below = 1'b1; end
      LV_MID:  begin above = 1'b0; below = 1'b0; end
      default: begin above = 1'b1; below = 1'b1; end
    endcase
    repeat (n) begin
      @(negedge clk);
      n_all++;
      if (cmd == 2'b01) n_hi++;
      if (cmd == 2'b00) n_lo++;
      if (cmd == 2'b10) n_tri++;
      if (gl) n_gl++;
      if (gh) n_gh++;
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    #(200000 * 4);
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clear();
    run(LV_MID, 5);
    rst = 1'b0;
    // R3 / R2 reset state
    chk("R3 reset cmd", int'(cmd), 2);
    chk("R3 reset gl flag", int'(gl), 1);
    chk("R3 reset gh flag", int'(gh), 1);

    // R9 exit from reset toward low after EXT valid samples
    run(LV_LOW, 1 + EXT);
    chk("R9 still tri before exit", int'(cmd), 2);
    run(LV_LOW, 1);
    chk("R9 exit to low cmd", int'(cmd), 0);
    chk("R9 both flags cleared", int'(gl) + int'(gh), 0);
    run(LV_LOW, 30);

    // R1 latency
    run(LV_HIGH, 2);
    chk("R1 not yet high", int'(cmd), 0);
    run(LV_HIGH, 1);
    chk("R1 high on third edge", int'(cmd), 1);
    run(LV_HIGH, 30);

    // R5 low pulse sweep
    for (int p = 1; p <= MLO + 3; p++) begin
      clear();
      run(LV_LOW, p);
      run(LV_HIGH, 40);
      chk($sformatf("R5 low width p=%0d", p), n_lo, imax(p, MLO));
      chk($sformatf("R5 no tri p=%0d", p), n_tri, 0);
    end

    // R4 high pulse sweep
    run(LV_LOW, 40);
    for (int p = 1; p <= MHI + 4; p++) begin
      clear();
      run(LV_HIGH, p);
      run(LV_LOW, 40);
      chk($sformatf("R4 high width p=%0d", p), n_hi, imax(p, MHI));
    end

    // R6 / R7 / R11 mid burst sweep
    for (int p = 1; p <= HGL + 2; p++) begin
      clear();
      run(LV_MID, p);
      run(LV_LOW, 50);
      chk($sformatf("R6 gh duration p=%0d", p), n_gh, (p >= HGH) ? p + EXT - HGH : 0);
      chk($sformatf("R7 gl duration p=%0d", p), n_gl, (p >= HGL) ? p + EXT - HGL : 0);
      chk($sformatf("R11 tri duration p=%0d", p), n_tri, (p >= HGH) ? p + EXT - HGH : 0);
      chk($sformatf("R2 no high p=%0d", p), n_hi, 0);
    end

    // R8 split mid bursts never reach the hold-off
    clear();
    run(LV_MID, HGH - 1);
    run(LV_LOW, 2);
    run(LV_MID, HGH - 1);
    run(LV_LOW, 40);
    chk("R8 split burst gh", n_gh, 0);
    chk("R8 split burst stays low", n_lo, n_all);

    // R11 short mid from high keeps high; long mid goes tri
    run(LV_HIGH, 30);
    clear();
    run(LV_MID, HGH - 1);
    run(LV_HIGH, 30);
    chk("R11 high kept before hold-off", n_hi, n_all);
    run(LV_MID, 40);
    chk("R11 tri after long mid", int'(cmd), 2);
    chk("R11 both flags after long mid", int'(gl) + int'(gh), 2);

    // R9 exit toward high
    run(LV_HIGH, 1 + EXT);
    chk("R9 exit high still tri", int'(cmd), 2);
    run(LV_HIGH, 1);
    chk("R9 exit to high", int'(cmd), 1);
    run(LV_HIGH, 20);

    // R9 mid during exit restarts the count
    run(LV_MID, 40);
    run(LV_LOW, EXT - 1);
    run(LV_MID, 5);
    chk("R9 tri after interrupted exit", int'(cmd), 2);
    run(LV_LOW, 1 + EXT);
    chk("R9 restart still tri", int'(cmd), 2);
    run(LV_LOW, 1);
    chk("R9 restart then low", int'(cmd), 0);
    run(LV_LOW, 20);

    // R10 invalid holds a high command
    run(LV_HIGH, 30);
    clear();
    run(LV_BAD, 40);
    chk("R10 invalid keeps high", n_hi, 40);
    run(LV_HIGH, 20);

    // R10 invalid holds tri-state
    run(LV_MID, 40);
    clear();
    run(LV_BAD, 30);
    chk("R10 invalid keeps tri", n_tri, 30);
    chk("R10 invalid keeps gl", n_gl, 30);

    // R10 invalid freezes the exit count
    run(LV_MID, 10);
    run(LV_LOW, EXT - 1);
    run(LV_BAD, 5);
    run(LV_LOW, 2);
    chk("R10 exit count held, still tri", int'(cmd), 2);
    run(LV_LOW, 1);
    chk("R10 exit completes after hold", int'(cmd), 0);
    run(LV_LOW, 10);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule